// File: doc/BRIEF.md
# Laser-Synchronous Acquisition Burst Sequencer

This block runs one timed acquisition burst for a battery-powered optical instrument. A register interface hands it a start command and a two-bit run-length code. From then on the block counts frame strobes that the serial audio capture logic produces, one strobe per stereo sample frame. Each strobe marks a frame boundary. Sixteen frames form one packet, and each packet is one full period of the laser drive. The laser power-select output is high for the first half of every packet and low for the second half. It changes only on frame boundaries, so every packet lines up exactly with one laser cycle.

The burst starts on the first frame boundary after the start command. Capture is enabled for the whole burst. When the last frame of the last packet ends, the block drops its busy flag, turns off capture and the laser, and raises a level interrupt. The interrupt stays up until the next start or a reset. The master clock may be gated off while the block is idle, because all state is held in registers.

Top module: `laser_burst_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `irq`, `laser_hi` and `capture_en` are all 0.
- R2: A `start` pulse while idle sets `busy` to 1 and clears `irq` on the next cycle. `laser_hi` and `capture_en` stay 0 until the first `frame_strobe` after the start.
- R3: On the cycle after the first `frame_strobe` following a start, `capture_en` is 1 and `laser_hi` is 1. `capture_en` stays 1 for every frame of the burst.
- R4: Number the burst's frames from 0, with frame 0 beginning at the first strobe. Within each packet of 16 frames, `laser_hi` is 1 for packet frames 0 to 7 and 0 for packet frames 8 to 15. It changes only on the cycle after a `frame_strobe`.
- R5: `len_code` sets the burst length in packets: 2'b00 gives 32, 2'b01 gives 64, 2'b10 gives 1024 and 2'b11 gives 2048. The burst ends at strobe number 1 + 16*packets, counting the first strobe after start as 1.
- R6: On the cycle after the final strobe, `busy`, `capture_en` and `laser_hi` go to 0 and `irq` goes to 1, all in that same cycle.
- R7: `irq` stays 1 while idle until either a `start` or `rst`. Either one clears it on the next cycle.
- R8: `len_code` is sampled only when an idle start is accepted. A `start` pulse or a `len_code` change while `busy` has no effect on the burst length or the laser pattern.
- R9: `frame_strobe` pulses while idle leave `laser_hi`, `capture_en`, `busy` and `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (nominally 8 MHz, may be gated while idle) |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle start command |
| len_code | input | 2 | Run-length code, sampled at start |
| frame_strobe | input | 1 | One-cycle pulse at each sample frame boundary |
| laser_hi | output | 1 | Laser level select: 1 = high current, 0 = low current |
| capture_en | output | 1 | Sample capture enable for the burst |
| busy | output | 1 | Burst armed or in progress |
| irq | output | 1 | End-of-collection interrupt, active high |

## Verification
The bench runs all four length codes to completion and predicts the laser level at every strobe from the strobe count. A design that is off by one in the frame or packet counters would end the burst one frame or one packet early or late. A design that flipped the laser phase would show as a mismatch within the first packet. Between strobes the bench checks that the laser holds still, which catches a design that toggles on clock counts rather than on frame boundaries. The bench also changes the length code and pulses start both in the armed wait and mid-burst. A design that re-samples the code or restarts on those events would finish at the wrong strobe. The bench also checks that the interrupt survives idle frame strobes and is cleared by a new start and by reset, so a pulsed or self-clearing interrupt fails.

// File: rtl/laser_burst_pkg.sv
package laser_burst_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ARM  = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_t;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/lbs_len_decode.sv
module lbs_len_decode #(
  parameter int unsigned PKT_W    = 12,
  parameter int unsigned PKT_LEN0 = 32,
  parameter int unsigned PKT_LEN1 = 64,
  parameter int unsigned PKT_LEN2 = 1024,
  parameter int unsigned PKT_LEN3 = 2048
) (
  input  logic [1:0]       code,
  output logic [PKT_W-1:0] packets
);

  always_comb begin
    unique case (code)
      2'b00:   packets = PKT_W'(PKT_LEN0);
      2'b01:   packets = PKT_W'(PKT_LEN1);
      2'b10:   packets = PKT_W'(PKT_LEN2);
      default: packets = PKT_W'(PKT_LEN3);
    endcase
  end

endmodule

// File: rtl/lbs_frame_ctr.sv
module lbs_frame_ctr #(
  parameter int unsigned FRAMES  = 16,
  localparam int unsigned FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               adv,
  output logic [FRAME_W-1:0] idx,
  output logic               last
);

  assign last = (idx == FRAME_W'(FRAMES - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx <= '0;
    end else if (adv) begin
      idx <= last ? '0 : idx + FRAME_W'(1);
    end
  end

endmodule

// File: rtl/lbs_pkt_ctr.sv
module lbs_pkt_ctr #(
  parameter int unsigned PKT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             adv,
  input  logic [PKT_W-1:0] limit,
  output logic             last
);

  logic [PKT_W-1:0] cnt;

  assign last = (cnt == limit - PKT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= cnt + PKT_W'(1);
    end
  end

endmodule

// File: rtl/laser_burst_seq.sv
module laser_burst_seq
  import laser_burst_pkg::*;
#(
  parameter int unsigned FRAMES_PER_PKT = 16,
  parameter int unsigned PKT_LEN0       = 32,
  parameter int unsigned PKT_LEN1       = 64,
  parameter int unsigned PKT_LEN2       = 1024,
  parameter int unsigned PKT_LEN3       = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] len_code,
  input  logic       frame_strobe,
  output logic       laser_hi,
  output logic       capture_en,
  output logic       busy,
  output logic       irq
);

  localparam int unsigned HIGH_FRAMES = FRAMES_PER_PKT / 2;
  localparam int unsigned FRAME_W     = (FRAMES_PER_PKT > 1) ? $clog2(FRAMES_PER_PKT) : 1;
  localparam int unsigned MAX_PKTS    = max4(PKT_LEN0, PKT_LEN1, PKT_LEN2, PKT_LEN3);
  localparam int unsigned PKT_W       = $clog2(MAX_PKTS + 1);
  localparam logic [FRAME_W:0] HIGH_LIM = (FRAME_W+1)'(HIGH_FRAMES);

  seq_state_t state_q;

  logic [PKT_W-1:0]   pkts_dec;
  logic [PKT_W-1:0]   limit_q;
  logic [FRAME_W-1:0] frame_idx;
  logic               frame_last;
  logic               pkt_last;
  logic [FRAME_W:0]   next_idx;

  logic go;
  logic arm_hit;
  logic run_stb;
  logic done;

  assign go      = start && (state_q == SEQ_IDLE);
  assign arm_hit = frame_strobe && (state_q == SEQ_ARM);
  assign run_stb = frame_strobe && (state_q == SEQ_RUN);
  assign done    = run_stb && frame_last && pkt_last;
  assign next_idx = frame_last ? '0 : ({1'b0, frame_idx} + (FRAME_W+1)'(1));

  lbs_len_decode #(
    .PKT_W   (PKT_W),
    .PKT_LEN0(PKT_LEN0),
    .PKT_LEN1(PKT_LEN1),
    .PKT_LEN2(PKT_LEN2),
    .PKT_LEN3(PKT_LEN3)
  ) i_len_decode (
    .code   (len_code),
    .packets(pkts_dec)
  );

  lbs_frame_ctr #(
    .FRAMES(FRAMES_PER_PKT)
  ) i_frame_ctr (
    .clk  (clk),
    .rst  (rst),
    .clear(go || arm_hit),
    .adv  (run_stb),
    .idx  (frame_idx),
    .last (frame_last)
  );

  lbs_pkt_ctr #(
    .PKT_W(PKT_W)
  ) i_pkt_ctr (
    .clk  (clk),
    .rst  (rst),
    .clear(go),
    .adv  (run_stb && frame_last),
    .limit(limit_q),
    .last (pkt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_IDLE;
      limit_q    <= '0;
      laser_hi   <= 1'b0;
      capture_en <= 1'b0;
      busy       <= 1'b0;
      irq        <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (go) begin
            state_q <= SEQ_ARM;
            limit_q <= pkts_dec;
            busy    <= 1'b1;
            irq     <= 1'b0;
          end
        end
        SEQ_ARM: begin
          if (arm_hit) begin
            state_q    <= SEQ_RUN;
            laser_hi   <= 1'b1;
            capture_en <= 1'b1;
          end
        end
        SEQ_RUN: begin
          if (done) begin
            state_q    <= SEQ_IDLE;
            laser_hi   <= 1'b0;
            capture_en <= 1'b0;
            busy       <= 1'b0;
            irq        <= 1'b1;
          end else if (run_stb) begin
            laser_hi <= (next_idx < HIGH_LIM);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lbs_checker.sv
module lbs_checker (
  input logic clk,
  input logic rst,
  input logic start,
  input logic frame_strobe,
  input logic laser_hi,
  input logic capture_en,
  input logic busy,
  input logic irq
);

  // R1, R9: idle means laser low and capture off
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!laser_hi && !capture_en));

  // R2: idle start arms the block and clears the interrupt
  a_r2_start_arms: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !irq));

  // R3: capture only within a burst
  a_r3_capture_in_burst: assert property (@(posedge clk) disable iff (rst)
    capture_en |-> busy);

  // R4: laser moves only right after a frame boundary
  a_r4_laser_on_frame: assert property (@(posedge clk) disable iff (rst)
    !$stable(laser_hi) |-> $past(frame_strobe));

  // R6: busy falling (not by reset) raises the interrupt
  a_r6_end_irq: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> irq);

  // R6: interrupt and busy never overlap
  a_r6_irq_busy_excl: assert property (@(posedge clk) disable iff (rst)
    !(irq && busy));

  // R7: interrupt is held until a start
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !start) |=> irq);

endmodule

bind laser_burst_seq lbs_checker i_lbs_checker (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .frame_strobe(frame_strobe),
  .laser_hi    (laser_hi),
  .capture_en  (capture_en),
  .busy        (busy),
  .irq         (irq)
);

// File: tb/test_laser_burst_seq.sv
module test_laser_burst_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] len_code = 2'b00;
  logic       frame_strobe = 1'b0;
  logic       laser_hi, capture_en, busy, irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  laser_burst_seq i_laser_burst_seq (
    .clk(clk), .rst(rst), .start(start), .len_code(len_code),
    .frame_strobe(frame_strobe), .laser_hi(laser_hi),
    .capture_en(capture_en), .busy(busy), .irq(irq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic idle_strobes(input logic exp_irq);
    for (int i = 0; i < 5; i++) begin
      frame_strobe = 1'b1;
      tick();
      frame_strobe = 1'b0;
      tick();
      chk("R9 idle laser", laser_hi, 1'b0);
      chk("R9 idle capture", capture_en, 1'b0);
      chk("R9 idle busy", busy, 1'b0);
      chk("R9 idle irq", irq, exp_irq);
    end
  endtask

  // code: length code; npk: expected packets; gap: cycles per strobe
  // inject: strobe index after which a start is pulsed while busy (0 = none)
  task automatic run_burst(input logic [1:0] code, input int npk, input int gap,
                           input int inject);
    int last_k;
    logic exp_l;
    logic exp_b;
    last_k = 1 + 16 * npk;
    len_code = code;
    start = 1'b1;
    tick();
    start = 1'b0;
    len_code = ~code;  // R8: code changes after acceptance must not matter
    chk("R2 busy after start", busy, 1'b1);
    chk("R2 irq cleared by start", irq, 1'b0);
    chk("R2 laser low before frame", laser_hi, 1'b0);
    chk("R2 capture off before frame", capture_en, 1'b0);
    // R8: second start while armed is ignored
    start = 1'b1;
    tick();
    start = 1'b0;
    tick();
    chk("R2 laser still low while armed", laser_hi, 1'b0);
    chk("R8 armed start keeps busy", busy, 1'b1);
    for (int k = 1; k <= last_k; k++) begin
      frame_strobe = 1'b1;
      tick();
      frame_strobe = 1'b0;
      exp_b = (k != last_k);
      exp_l = exp_b && (((k - 1) % 16) < 8);
      if (k == 1) chk("R3 first frame capture", capture_en, 1'b1);
      if (exp_b) begin
        chk("R4 laser pattern", laser_hi, exp_l);
        chk("R5 busy during burst", busy, 1'b1);
        chk("R3 capture during burst", capture_en, 1'b1);
      end else begin
        chk("R5/R6 busy at end", busy, 1'b0);
        chk("R6 irq at end", irq, 1'b1);
        chk("R6 laser off at end", laser_hi, 1'b0);
        chk("R6 capture off at end", capture_en, 1'b0);
      end
      for (int g = 1; g < gap; g++) begin
        if (inject != 0 && k == inject && g == 1) begin
          start = 1'b1;
          len_code = 2'b00;
        end
        tick();
        start = 1'b0;
        chk("R4 laser held between frames", laser_hi, exp_l);
        chk("R8 busy unaffected", busy, exp_b);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1 reset busy", busy, 1'b0);
    chk("R1 reset irq", irq, 1'b0);
    chk("R1 reset laser", laser_hi, 1'b0);
    chk("R1 reset capture", capture_en, 1'b0);

    idle_strobes(1'b0);

    run_burst(2'b00, 32, 3, 0);
    repeat (10) tick();
    chk("R7 irq held idle", irq, 1'b1);
    idle_strobes(1'b1);

    run_burst(2'b01, 64, 2, 100);
    chk("R7 irq held after second burst", irq, 1'b1);

    run_burst(2'b10, 1024, 2, 0);
    run_burst(2'b11, 2048, 2, 0);

    rst = 1'b1;
    tick();
    rst = 1'b0;
    tick();
    chk("R7 irq cleared by reset", irq, 1'b0);
    chk("R1 busy after late reset", busy, 1'b0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule